// File: doc/BRIEF.md
# Halfword-Pair Instruction Prefetch Unit

This block is the front end of a two-stage fetch/execute pipeline for an instruction set whose instructions are mostly 16 bits wide. Each fetch reads one aligned 32-bit word, which holds two halfwords. The unit shares a single pipelined 32-bit bus master with load/store traffic. The address goes out in one cycle and the data comes back in the next cycle, with no wait states. Because a word covers two 16-bit instructions, the unit fetches at most every other cycle in straight-line code. The cycles without a fetch leave the bus free for a data access.

Fetched halfwords go into a small shift queue. The execute stage takes one instruction per cycle from the head of the queue. A 32-bit instruction is handed over only when both of its halfwords are present, even when the two halves come from different words. A taken branch empties the queue. It also cancels every fetch issued up to and including the branch cycle, so at most the two shadow halfwords of one word are thrown away. Fetching then restarts at the word that holds the target.

The fetch controller has two states. In FS_ARMED a fetch may be issued. In FS_REST it may not. The transitions are:
- issue (FS_ARMED to FS_REST): a word fetch was placed on the bus.
- hold (FS_ARMED to FS_ARMED): a data request owns the bus, or the queue has no room.
- resume (FS_REST to FS_ARMED): the idle cycle after an issue.
- redirect (either state to FS_ARMED): a branch was taken.

Top module: `hwpair_prefetch`

## Requirements
- R1: While reset is released and before the first clock edge, `fetch_req` is 1, `fetch_addr` equals the reset vector aligned down to a word, and `ins_valid` is 0.
- R2: A cycle with `fetch_req` high and no branch is always followed by a cycle with `fetch_req` low.
- R3: In any cycle with `dreq` high, `fetch_req` is low. A fetch that was held back is issued once `dreq` falls, and no instruction is lost or duplicated.
- R4: In straight-line 16-bit code with `ins_ready` held high, one instruction is accepted every cycle, in address order, with `ins_pc` going up by 2 each time.
- R5: A halfword whose bits [15:11] are 11101, 11110 or 11111 starts a 32-bit instruction. It is presented as `ins_data` = {first halfword, second halfword} with `ins_wide` = 1. Any other halfword, including prefix 11100, is a 16-bit instruction.
- R6: A 32-bit instruction whose first halfword is the upper half of a word is held back until the next word arrives, and is then presented whole. A presented item that is not accepted stays valid and unchanged.
- R7: In the cycle after a branch (`br_valid` high), with `dreq` low, `fetch_req` is 1 and `fetch_addr` is the target aligned down to a word. Halfwords from earlier fetches are never presented.
- R8: For a branch target whose bit 1 is set, the lower halfword of the fetched word is dropped. The first instruction presented after the branch has `ins_pc` equal to the target.
- R9: A 16-bit instruction is presented in `ins_data[15:0]`, with `ins_data[31:16]` zero and `ins_wide` 0.
- R10: The halfword queue never holds more than its depth. A fetch is only issued when the queue has room for the word, counting any fetch still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Word fetch address phase this cycle |
| fetch_addr | output | 32 | Word-aligned fetch address |
| fetch_rdata | input | 32 | Read data for the fetch issued in the previous cycle; the lower halfword is the lower address |
| dreq | input | 1 | A data access wants the bus this cycle (has priority) |
| br_valid | input | 1 | Taken branch redirect, one cycle |
| br_target | input | 32 | Branch target halfword address |
| ins_valid | output | 1 | Instruction presented to execute |
| ins_ready | input | 1 | Execute accepts the presented instruction |
| ins_wide | output | 1 | Presented instruction is 32 bits |
| ins_data | output | 32 | Presented instruction |
| ins_pc | output | 32 | Address of the presented instruction |

## Verification
The fetch outputs are combinational from state. The redirect fetch is checked in the first cycle after the branch, and the reset fetch is checked before the first edge. Returned data is written into the queue at the end of the cycle after its address, so a target instruction becomes visible three cycles after the branch. The scoreboard therefore compares items only when the execute handshake completes, not at fixed delays. All stimulus and all sampling happen one time unit after the rising edge or at the falling edge. The sustained-rate check compares the cycle numbers of the first and last acceptance in a segment of 16-bit code.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

    localparam int HW_W = 16;

    typedef enum logic [0:0] {
        FS_ARMED = 1'b0,
        FS_REST  = 1'b1
    } fetch_state_e;

    // 32-bit instruction when the top five bits are 11101, 11110 or 11111.
    function automatic logic is_wide_hw(input logic [HW_W-1:0] h);
        return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
    endfunction

endpackage

// File: rtl/pfu_fetch_ctl.sv
module pfu_fetch_ctl
    import pfu_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0100,
    parameter int          DEPTH     = 4,
    parameter int          CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dreq,
    input  logic             br_valid,
    input  logic [31:0]      br_target,
    input  logic [CNT_W-1:0] q_count,
    output logic             fetch_req,
    output logic [31:0]      fetch_addr,
    output logic             rsp_valid,
    output logic             rsp_skip_lo
);

    fetch_state_e state_q, state_d;
    logic [31:0]  fetch_pc_q;
    logic         skip_next_q;
    logic         pend_v_q;
    logic         pend_skip_q;
    logic         space_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_ARMED;
        else        state_q <= state_d;
    end

    // Outputs and next state
    always_comb begin
        space_ok   = (int'(q_count) + (pend_v_q ? 2 : 0) + 2) <= DEPTH;
        fetch_req  = 1'b0;
        fetch_addr = fetch_pc_q;
        state_d    = state_q;
        unique case (state_q)
            FS_ARMED: begin
                fetch_req = !dreq && space_ok;
                if (br_valid)       state_d = FS_ARMED;  // redirect
                else if (fetch_req) state_d = FS_REST;   // issue
                else                state_d = FS_ARMED;  // hold
            end
            FS_REST: begin
                fetch_req = 1'b0;
                state_d   = FS_ARMED;                    // resume / redirect
            end
        endcase
        rsp_valid   = pend_v_q && !br_valid;
        rsp_skip_lo = pend_skip_q;
    end

    // Fetch address, alignment skip and in-flight tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc_q  <= RESET_VEC & 32'hFFFF_FFFC;
            skip_next_q <= RESET_VEC[1];
            pend_v_q    <= 1'b0;
            pend_skip_q <= 1'b0;
        end else begin
            pend_v_q    <= fetch_req && !br_valid;
            pend_skip_q <= skip_next_q;
            if (br_valid) begin
                fetch_pc_q  <= br_target & 32'hFFFF_FFFC;
                skip_next_q <= br_target[1];
            end else if (fetch_req) begin
                fetch_pc_q  <= fetch_pc_q + 32'd4;
                skip_next_q <= 1'b0;
            end
        end
    end

    p_fetch_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !br_valid) |=> !fetch_req);

    p_dreq_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> !fetch_req);

    p_redirect_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_valid) && !dreq) |->
            (fetch_req && fetch_addr == ($past(br_target) & 32'hFFFF_FFFC)));

    p_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (int'(q_count) <= DEPTH - 2));

endmodule

// File: rtl/pfu_hw_queue.sv
module pfu_hw_queue
    import pfu_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       pop_n,
    input  logic             push_v,
    input  logic             push_skip_lo,
    input  logic [31:0]      push_word,
    output logic [CNT_W-1:0] count,
    output logic [HW_W-1:0]  hw0,
    output logic [HW_W-1:0]  hw1
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [HW_W-1:0]  mem_q [DEPTH];
    logic [HW_W-1:0]  mem_d [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [HW_W-1:0]  ph0, ph1;
    int               remain;
    int               pn;

    always_comb begin
        remain = int'(cnt_q) - int'(pop_n);
        if (push_skip_lo) begin
            ph0 = push_word[31:16];
            ph1 = '0;
            pn  = 1;
        end else begin
            ph0 = push_word[15:0];
            ph1 = push_word[31:16];
            pn  = 2;
        end
        if (!push_v) pn = 0;
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (i < remain) begin
                if (i + int'(pop_n) < DEPTH)
                    mem_d[i] = mem_q[IDX_W'(i + int'(pop_n))];
            end else if ((i - remain) == 0 && pn >= 1) begin
                mem_d[i] = ph0;
            end else if ((i - remain) == 1 && pn == 2) begin
                mem_d[i] = ph1;
            end
        end
        cnt_d = flush ? '0 : CNT_W'(remain + pn);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign count = cnt_q;
    assign hw0   = mem_q[0];
    assign hw1   = mem_q[1];

    p_pop_within_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(count));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_v |-> (int'(count) - int'(pop_n) + (push_skip_lo ? 1 : 2) <= DEPTH));

endmodule

// File: rtl/pfu_issue.sv
module pfu_issue
    import pfu_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0100,
    parameter int          CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW_W-1:0]  hw0,
    input  logic [HW_W-1:0]  hw1,
    input  logic [CNT_W-1:0] q_count,
    input  logic             ins_ready,
    input  logic             br_valid,
    input  logic [31:0]      br_target,
    output logic             ins_valid,
    output logic             ins_wide,
    output logic [31:0]      ins_data,
    output logic [31:0]      ins_pc,
    output logic [1:0]       pop_n
);

    logic [31:0] head_pc_q;

    always_comb begin
        ins_wide  = is_wide_hw(hw0);
        ins_valid = ins_wide ? (int'(q_count) >= 2) : (int'(q_count) >= 1);
        ins_data  = ins_wide ? {hw0, hw1} : {16'h0000, hw0};
        ins_pc    = head_pc_q;
        if (ins_valid && ins_ready && !br_valid)
            pop_n = ins_wide ? 2'd2 : 2'd1;
        else
            pop_n = 2'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        head_pc_q <= RESET_VEC & 32'hFFFF_FFFE;
        else if (br_valid) head_pc_q <= br_target & 32'hFFFF_FFFE;
        else               head_pc_q <= head_pc_q + {29'd0, pop_n, 1'b0};
    end

    p_hold_whole_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready && !br_valid) |=> (ins_valid && $stable(ins_data)));

    p_target_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_valid)) |->
            (!ins_valid && ins_pc == ($past(br_target) & 32'hFFFF_FFFE)));

    p_narrow_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_wide) |-> (ins_data[31:16] == 16'h0000));

endmodule

// File: rtl/hwpair_prefetch.sv
module hwpair_prefetch
    import pfu_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0100,
    parameter int          QDEPTH    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        fetch_req,
    output logic [31:0] fetch_addr,
    input  logic [31:0] fetch_rdata,
    input  logic        dreq,
    input  logic        br_valid,
    input  logic [31:0] br_target,
    output logic        ins_valid,
    input  logic        ins_ready,
    output logic        ins_wide,
    output logic [31:0] ins_data,
    output logic [31:0] ins_pc
);

    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic [CNT_W-1:0] q_count;
    logic [HW_W-1:0]  hw0, hw1;
    logic [1:0]       pop_n;
    logic             rsp_valid, rsp_skip_lo;

    pfu_fetch_ctl #(.RESET_VEC(RESET_VEC), .DEPTH(QDEPTH), .CNT_W(CNT_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .br_valid(br_valid),
        .br_target(br_target), .q_count(q_count), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .rsp_valid(rsp_valid), .rsp_skip_lo(rsp_skip_lo)
    );

    pfu_hw_queue #(.DEPTH(QDEPTH), .CNT_W(CNT_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(br_valid), .pop_n(pop_n),
        .push_v(rsp_valid), .push_skip_lo(rsp_skip_lo), .push_word(fetch_rdata),
        .count(q_count), .hw0(hw0), .hw1(hw1)
    );

    pfu_issue #(.RESET_VEC(RESET_VEC), .CNT_W(CNT_W)) u_issue (
        .clk(clk), .rst_n(rst_n), .hw0(hw0), .hw1(hw1), .q_count(q_count),
        .ins_ready(ins_ready), .br_valid(br_valid), .br_target(br_target),
        .ins_valid(ins_valid), .ins_wide(ins_wide), .ins_data(ins_data),
        .ins_pc(ins_pc), .pop_n(pop_n)
    );

    p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_addr[1:0] == 2'b00));

endmodule

// File: tb/sim_hwpair_prefetch.sv
`timescale 1ns/1ps
module sim_hwpair_prefetch;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] data;
        logic        wide;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic [31:0] fetch_rdata;
    logic        dreq = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_target = '0;
    logic        ins_valid;
    logic        ins_ready = 1'b0;
    logic        ins_wide;
    logic [31:0] ins_data;
    logic [31:0] ins_pc;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    seg_acc = 0;
    int    first_acc = -1;
    int    last_acc = -1;
    bit    done = 1'b0;
    logic  prev_fetch = 1'b0;
    logic  prev_br = 1'b0;
    logic [31:0] mp_a = '0;
    item_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    hwpair_prefetch #(.RESET_VEC(32'h0000_0100), .QDEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rdata(fetch_rdata), .dreq(dreq), .br_valid(br_valid),
        .br_target(br_target), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_wide(ins_wide), .ins_data(ins_data), .ins_pc(ins_pc)
    );

    // Program image: a few 32-bit starts placed on both halves of a word.
    function automatic logic [15:0] prog(input logic [31:0] a);
        case (a)
            32'h10A: return {5'b11110, 11'h005};
            32'h110: return {5'b11101, 11'h008};
            32'h116: return {5'b11111, 11'h00B};
            32'h11C: return {5'b11100, 11'h00E};
            default: return {4'h0, a[12:1]};
        endcase
    endfunction

    function automatic bit wide_start(input logic [15:0] h);
        return (h[15:11] == 5'b11101) || (h[15:11] == 5'b11110) || (h[15:11] == 5'b11111);
    endfunction

    // Bus model: data phase one cycle after the address phase.
    always @(posedge clk) mp_a <= fetch_addr;
    assign fetch_rdata = {prog(mp_a + 32'd2), prog(mp_a)};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung (actual cycle %0d, expected < 20000)", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pops at each completed handshake; bus rules R2/R3.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ins_valid && ins_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected item", ins_pc, 32'hFFFF_FFFF);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(ins_pc == e.pc, "R4 pc order", ins_pc, e.pc);
                    check(ins_data == e.data, e.wide ? "R5/R6 wide data" : "R9 narrow data", ins_data, e.data);
                    check(ins_wide == e.wide, "R5 wide flag", {31'd0, ins_wide}, {31'd0, e.wide});
                end
                if (first_acc < 0) first_acc = cyc;
                last_acc = cyc;
                seg_acc = seg_acc + 1;
            end
            if (fetch_req)
                check(!(prev_fetch && !prev_br), "R2 fetch gap", {31'd0, prev_fetch}, 32'd0);
            if (dreq)
                check(!fetch_req, "R3 data priority", {31'd0, fetch_req}, 32'd0);
            prev_fetch = fetch_req;
            prev_br = br_valid;
        end
    end

    // Driver: queue the expected stream, then pace the execute handshake.
    task automatic run_segment(input logic [31:0] start, input int k,
                               input bit toggle, input int dq_from, input int dq_len);
        logic [31:0] p;
        int n;
        p = start;
        for (int i = 0; i < k; i++) begin
            logic [15:0] h;
            item_t it;
            h = prog(p);
            if (wide_start(h)) begin
                it = '{pc: p, data: {h, prog(p + 32'd2)}, wide: 1'b1};
                p = p + 32'd4;
            end else begin
                it = '{pc: p, data: {16'h0000, h}, wide: 1'b0};
                p = p + 32'd2;
            end
            exp_q.push_back(it);
        end
        seg_acc = 0;
        first_acc = -1;
        last_acc = -1;
        n = 0;
        forever begin
            @(posedge clk); #1;
            if (seg_acc >= k) break;
            n = n + 1;
            ins_ready = !(toggle && (n % 3 == 0));
            dreq = (n >= dq_from) && (n < dq_from + dq_len);
        end
        ins_ready = 1'b0;
        dreq = 1'b0;
    endtask

    task automatic take_branch(input logic [31:0] tgt);
        br_valid = 1'b1;
        br_target = tgt;
        @(posedge clk); #1;
        br_valid = 1'b0;
        // R7: redirect fetch in the cycle right after the branch
        check(fetch_req == 1'b1, "R7 redirect req", {31'd0, fetch_req}, 32'd1);
        check(fetch_addr == (tgt & 32'hFFFF_FFFC), "R7 redirect addr", fetch_addr, tgt & 32'hFFFF_FFFC);
        check(ins_valid == 1'b0, "R7 no stale item", {31'd0, ins_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(fetch_req == 1'b1, "R1 reset fetch", {31'd0, fetch_req}, 32'd1);
        check(fetch_addr == 32'h100, "R1 reset vector", fetch_addr, 32'h100);
        check(ins_valid == 1'b0, "R1 empty at reset", {31'd0, ins_valid}, 32'd0);

        // Wide instructions on both halves, plus the 11100 boundary (R5, R6)
        run_segment(32'h100, 16, 1'b0, 0, 0);
        take_branch(32'h202);
        // Odd-halfword target, execute stalls and a data burst (R8, R6, R3)
        run_segment(32'h202, 8, 1'b1, 3, 3);
        take_branch(32'h300);
        // Sustained rate (R4)
        run_segment(32'h300, 10, 1'b0, 0, 0);
        check((last_acc - first_acc) == 9, "R4 one per cycle",
              32'(last_acc - first_acc), 32'd9);
        take_branch(32'h400);
        run_segment(32'h400, 4, 1'b0, 2, 2);
        repeat (4) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R10 stream complete", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule